// File: doc/BRIEF.md
# UART Receive Line Condition Monitor

This block sits beside an asynchronous serial receiver and turns what the receiver sees into line-condition events. It watches the raw receive line at each bit-rate sample tick. It also watches the character-complete strobe, which carries the received data, the stop-bit value and the error flags. From these inputs it keeps track of whether the line is idle or in a break. It also decides whether each completed character is handed to the receive buffer or dropped because no buffer is free.

Events are held as sticky bits in an event register. Each bit is cleared by writing a one to it. A mask register selects which events drive the single interrupt output. A live idle status bit shows the current line state in real time. Bit sampling, deserialization and buffer memory live outside the block. A character that is accepted leaves the block on a one-cycle store strobe.

Top module: `uart_line_monitor`

## Requirements
- R1: After reset, the event register, the mask register, the idle status and the interrupt output are all zero, and the store strobe is low.
- R2: A completed character whose data bits are all ones and whose stop bit is one sets the idle status. If the line was not already idle, it also sets event bit 0 (idle changed). Such a character arriving while the line is already idle raises no event.
- R3: A sample tick with the receive line at zero while idle clears the idle status and sets event bit 0. A sample tick with the line at one has no effect on the idle status.
- R4: A completed character with all data bits zero and a zero stop bit sets event bit 1 (break start) when no break is in progress. Further such characters in the same break set nothing.
- R5: Once a break is in progress, the first sample tick with the line at one sets event bit 2 (break end) and ends the break. Ticks with the line at one and no break in progress set no event bit.
- R6: A completed character that arrives while buffer-available is low is discarded. It sets event bit 3 (busy), gives no store strobe and does not set event bit 4.
- R7: An accepted character sets event bit 4 (receive-buffer event) when it closes the buffer or carries any of the parity, framing, overrun or carrier-lost flags. An accepted character with none of these sets no bit 4.
- R8: An accepted character appears on the store strobe and store data exactly one clock after its character-complete strobe, and the store strobe lasts one cycle.
- R9: Writing a one to an event bit clears it. A new event on the same bit in the same cycle leaves the bit set. Writing ones to other bits leaves a set bit untouched.
- R10: The interrupt output is high exactly when some event bit and its mask bit are both one. The mask is loaded from mask write data on a mask write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Raw receive line level |
| bit_tick | input | 1 | Bit-rate sample tick for rx_line |
| char_valid | input | 1 | Character-complete strobe (middle of first stop bit) |
| char_data | input | DATA_W | Received data bits |
| char_stop | input | 1 | Sampled value of the first stop bit |
| err_parity | input | 1 | Parity error on this character |
| err_framing | input | 1 | Framing error on this character |
| err_overrun | input | 1 | Overrun on this character |
| err_cd_lost | input | 1 | Carrier lost during this character |
| buf_close | input | 1 | This character closes the current buffer |
| buf_avail | input | 1 | A receive buffer is free |
| evt_clr | input | 5 | Write-one-to-clear strobes for event bits |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 5 | Mask register write data |
| evt | output | 5 | Sticky event register |
| mask | output | 5 | Mask register contents |
| irq | output | 1 | Masked OR of the event bits |
| idle_status | output | 1 | Live idle state of the line |
| store_valid | output | 1 | Accepted character strobe |
| store_data | output | DATA_W | Accepted character data |

## Verification
The idle tracker gets repeated all-ones characters and line ticks of both levels. This separates a real entry or exit from a repeat that must stay silent. Break handling uses a run of several break characters followed by zero and one ticks. This shows that the start fires once and the end fires only on the first one bit. Each character is sent with the buffer both free and taken, and with each error flag alone and with none. This separates the busy, buffer-event and plain-store cases. Clear strobes are driven alone, alongside a new event, and on a neighbouring bit, so that set-wins is distinguished from a plain clear.

// File: rtl/uart_mon_pkg.sv
package uart_mon_pkg;

  localparam int unsigned NUM_EVT = 5;

  typedef enum logic [2:0] {
    EV_IDLE_CHG = 3'd0,
    EV_BRK_BEG  = 3'd1,
    EV_BRK_FIN  = 3'd2,
    EV_BUSY     = 3'd3,
    EV_RXBUF    = 3'd4
  } evt_idx_e;

  function automatic logic is_mark_char(input logic [15:0] data, input int unsigned width,
                                        input logic stop);
    logic all1;
    all1 = 1'b1;
    for (int i = 0; i < 16; i++) begin
      if (i < int'(width)) all1 = all1 & data[i];
    end
    return all1 & stop;
  endfunction

  function automatic logic is_space_char(input logic [15:0] data, input int unsigned width,
                                         input logic stop);
    logic any1;
    any1 = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (i < int'(width)) any1 = any1 | data[i];
    end
    return ~any1 & ~stop;
  endfunction

  function automatic logic any_rx_error(input logic par, input logic frm, input logic ovr,
                                        input logic cdl);
    return par | frm | ovr | cdl;
  endfunction

endpackage

// File: rtl/line_state_tracker.sv
module line_state_tracker
  import uart_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              bit_tick,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_stop,
  output logic              idle_q,
  output logic              idle_chg,
  output logic              brk_beg,
  output logic              brk_fin
);

  logic [15:0] data_ext;
  logic        mark_char;
  logic        space_char;
  logic        zero_tick;
  logic        one_tick;
  logic        idle_nxt;
  logic        in_brk_q;

  assign data_ext   = 16'(char_data);
  assign mark_char  = char_valid & is_mark_char(data_ext, DATA_W, char_stop);
  assign space_char = char_valid & is_space_char(data_ext, DATA_W, char_stop);
  assign zero_tick  = bit_tick & ~rx_line;
  assign one_tick   = bit_tick & rx_line;

  always_comb begin
    idle_nxt = idle_q;
    if (mark_char) idle_nxt = 1'b1;
    if (zero_tick) idle_nxt = 1'b0;
  end

  assign idle_chg = idle_nxt ^ idle_q;
  assign brk_beg  = space_char & ~in_brk_q;
  assign brk_fin  = one_tick & in_brk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q   <= 1'b0;
      in_brk_q <= 1'b0;
    end else begin
      idle_q <= idle_nxt;
      if (brk_fin) in_brk_q <= 1'b0;
      else if (brk_beg) in_brk_q <= 1'b1;
    end
  end

  AST_IDLE_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    idle_chg |=> (idle_q != $past(idle_q))) else $error("idle change lost"); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !idle_chg |=> $stable(idle_q)) else $error("idle moved silently"); // R3

  AST_BRK_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_beg |=> !brk_beg) else $error("repeated break start"); // R4

  AST_FIN_AFTER_BEG: assert property (@(posedge clk) disable iff (!rst_n)
    brk_fin |=> !brk_fin) else $error("repeated break end"); // R5

endmodule

// File: rtl/rx_char_router.sv
module rx_char_router
  import uart_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              err_parity,
  input  logic              err_framing,
  input  logic              err_overrun,
  input  logic              err_cd_lost,
  input  logic              buf_close,
  input  logic              buf_avail,
  output logic              busy_hit,
  output logic              rxbuf_hit,
  output logic              store_valid,
  output logic [DATA_W-1:0] store_data
);

  logic accept;
  logic has_err;

  assign accept    = char_valid & buf_avail;
  assign has_err   = any_rx_error(err_parity, err_framing, err_overrun, err_cd_lost);
  assign busy_hit  = char_valid & ~buf_avail;
  assign rxbuf_hit = accept & (buf_close | has_err);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store_valid <= 1'b0;
      store_data  <= '0;
    end else begin
      store_valid <= accept;
      if (accept) store_data <= char_data;
    end
  end

  AST_DROP_NOT_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_hit |=> !store_valid) else $error("dropped char stored"); // R6

  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (store_valid && !$past(char_valid)) |-> 1'b0) else $error("store without char"); // R8

endmodule

// File: rtl/event_reg.sv
module event_reg #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] evt_q,
  output logic [N-1:0] mask_q,
  output logic         irq
);

  always_ff @(posedge clk) begin
    if (!rst_n) mask_q <= '0;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) evt_q[g] <= 1'b0;
      else if (set_i[g]) evt_q[g] <= 1'b1;
      else if (clr_i[g]) evt_q[g] <= 1'b0;
    end

    AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> evt_q[g]) else $error("event not latched"); // R9

    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !evt_q[g]) else $error("clear ignored"); // R9

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (!evt_q[g] && !set_i[g]) |=> !evt_q[g]) else $error("spurious event"); // R9
  end

  assign irq = |(evt_q & mask_q);

endmodule

// File: rtl/uart_line_monitor.sv
module uart_line_monitor
  import uart_mon_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              bit_tick,
  input  logic              char_valid,
  input  logic [DATA_W-1:0] char_data,
  input  logic              char_stop,
  input  logic              err_parity,
  input  logic              err_framing,
  input  logic              err_overrun,
  input  logic              err_cd_lost,
  input  logic              buf_close,
  input  logic              buf_avail,
  input  logic [4:0]        evt_clr,
  input  logic              mask_wr,
  input  logic [4:0]        mask_wdata,
  output logic [4:0]        evt,
  output logic [4:0]        mask,
  output logic              irq,
  output logic              idle_status,
  output logic              store_valid,
  output logic [DATA_W-1:0] store_data
);

  logic               idle_chg;
  logic               brk_beg;
  logic               brk_fin;
  logic               busy_hit;
  logic               rxbuf_hit;
  logic [NUM_EVT-1:0] evt_set;

  line_state_tracker #(.DATA_W(DATA_W)) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_line    (rx_line),
    .bit_tick   (bit_tick),
    .char_valid (char_valid),
    .char_data  (char_data),
    .char_stop  (char_stop),
    .idle_q     (idle_status),
    .idle_chg   (idle_chg),
    .brk_beg    (brk_beg),
    .brk_fin    (brk_fin)
  );

  rx_char_router #(.DATA_W(DATA_W)) u_route (
    .clk         (clk),
    .rst_n       (rst_n),
    .char_valid  (char_valid),
    .char_data   (char_data),
    .err_parity  (err_parity),
    .err_framing (err_framing),
    .err_overrun (err_overrun),
    .err_cd_lost (err_cd_lost),
    .buf_close   (buf_close),
    .buf_avail   (buf_avail),
    .busy_hit    (busy_hit),
    .rxbuf_hit   (rxbuf_hit),
    .store_valid (store_valid),
    .store_data  (store_data)
  );

  always_comb begin
    evt_set              = '0;
    evt_set[EV_IDLE_CHG] = idle_chg;
    evt_set[EV_BRK_BEG]  = brk_beg;
    evt_set[EV_BRK_FIN]  = brk_fin;
    evt_set[EV_BUSY]     = busy_hit;
    evt_set[EV_RXBUF]    = rxbuf_hit;
  end

  event_reg #(.N(NUM_EVT)) u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (evt_set),
    .clr_i      (evt_clr),
    .mask_wr    (mask_wr),
    .mask_wdata (mask_wdata),
    .evt_q      (evt),
    .mask_q     (mask),
    .irq        (irq)
  );

  AST_BUSY_NOT_RXBUF: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_hit && rxbuf_hit)) else $error("busy and rxbuf together"); // R6

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq) else $error("irq with empty mask"); // R10

endmodule

// File: tb/uart_line_monitor_tb.sv
`timescale 1ns/1ps
module uart_line_monitor_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_line, bit_tick, char_valid, char_stop;
  logic [7:0] char_data;
  logic       err_parity, err_framing, err_overrun, err_cd_lost;
  logic       buf_close, buf_avail, mask_wr;
  logic [4:0] evt_clr, mask_wdata;
  logic [4:0] evt, mask;
  logic       irq, idle_status, store_valid;
  logic [7:0] store_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  uart_line_monitor #(.DATA_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_tick(bit_tick),
    .char_valid(char_valid), .char_data(char_data), .char_stop(char_stop),
    .err_parity(err_parity), .err_framing(err_framing), .err_overrun(err_overrun),
    .err_cd_lost(err_cd_lost), .buf_close(buf_close), .buf_avail(buf_avail),
    .evt_clr(evt_clr), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .evt(evt), .mask(mask), .irq(irq), .idle_status(idle_status),
    .store_valid(store_valid), .store_data(store_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input logic stop);
    char_valid = 1'b1; char_data = d; char_stop = stop;
    step();
    char_valid = 1'b0; char_stop = 1'b1;
  endtask

  task automatic tick(input logic lvl);
    bit_tick = 1'b1; rx_line = lvl;
    step();
    bit_tick = 1'b0; rx_line = 1'b1;
  endtask

  task automatic clear_all();
    evt_clr = 5'h1f; step(); evt_clr = 5'h00;
  endtask

  task automatic t_reset();
    check("R1 evt", evt, 0); check("R1 mask", mask, 0);
    check("R1 idle", idle_status, 0); check("R1 irq", irq, 0);
    check("R1 store", store_valid, 0);
  endtask

  task automatic t_idle();
    send_char(8'hff, 1'b1);
    check("R2 idle set", idle_status, 1); check("R2 evt0", evt[0], 1);
    clear_all();
    send_char(8'hff, 1'b1);
    check("R2 repeat silent", evt[0], 0); check("R2 still idle", idle_status, 1);
    send_char(8'hfe, 1'b1);
    check("R2 non-mark char no entry effect", evt[0], 0);
    tick(1'b1);
    check("R3 one tick keeps idle", idle_status, 1); check("R3 one tick no evt", evt[0], 0);
    tick(1'b0);
    check("R3 idle exit", idle_status, 0); check("R3 evt0", evt[0], 1);
    clear_all();
    tick(1'b0);
    check("R3 zero tick not idle", evt[0], 0);
    clear_all();
  endtask

  task automatic t_break();
    send_char(8'h00, 1'b0);
    check("R4 break start", evt[1], 1);
    clear_all();
    send_char(8'h00, 1'b0);
    send_char(8'h00, 1'b0);
    check("R4 no second start", evt[1], 0);
    tick(1'b0);
    check("R5 zero tick no end", evt[2], 0);
    tick(1'b1);
    check("R5 break end", evt[2], 1);
    clear_all();
    tick(1'b1);
    check("R5 one tick outside break", evt[2], 0);
    send_char(8'h00, 1'b0);
    check("R4 new break starts again", evt[1], 1);
    tick(1'b1);
    clear_all();
  endtask

  task automatic t_busy();
    buf_avail = 1'b0; buf_close = 1'b1;
    send_char(8'h5a, 1'b1);
    check("R6 busy", evt[3], 1); check("R6 no rxbuf", evt[4], 0);
    check("R6 not stored", store_valid, 0);
    buf_avail = 1'b1;
    send_char(8'ha5, 1'b1);
    check("R7 close sets rxbuf", evt[4], 1);
    check("R8 store strobe", store_valid, 1); check("R8 store data", store_data, 8'ha5);
    step();
    check("R8 strobe one cycle", store_valid, 0);
    buf_close = 1'b0;
    clear_all();
  endtask

  task automatic t_rxbuf();
    send_char(8'h3c, 1'b1);
    check("R7 plain char no rxbuf", evt[4], 0);
    check("R8 plain stored", store_data, 8'h3c);
    for (int k = 0; k < 4; k++) begin
      err_parity  = (k == 0); err_framing = (k == 1);
      err_overrun = (k == 2); err_cd_lost = (k == 3);
      send_char(8'h11 + 8'(k), 1'b1);
      check($sformatf("R7 error flag %0d", k), evt[4], 1);
      err_parity = 0; err_framing = 0; err_overrun = 0; err_cd_lost = 0;
      clear_all();
    end
  endtask

  task automatic t_w1c();
    buf_avail = 1'b0;
    send_char(8'h01, 1'b1);
    evt_clr = 5'b01000; char_valid = 1'b1; char_data = 8'h02;
    step();
    char_valid = 1'b0; evt_clr = 5'h00;
    check("R9 set wins over clear", evt[3], 1);
    evt_clr = 5'b10111; step(); evt_clr = 5'h00;
    check("R9 other bits leave set", evt[3], 1);
    evt_clr = 5'b01000; step(); evt_clr = 5'h00;
    check("R9 clear", evt[3], 0);
    buf_avail = 1'b1;
  endtask

  task automatic t_irq();
    buf_avail = 1'b0;
    send_char(8'h01, 1'b1);
    buf_avail = 1'b1;
    check("R10 unmasked no irq", irq, 0);
    mask_wr = 1'b1; mask_wdata = 5'b00001; step(); mask_wr = 1'b0;
    check("R10 mask readback", mask, 5'b00001);
    check("R10 other mask no irq", irq, 0);
    mask_wr = 1'b1; mask_wdata = 5'b01000; step(); mask_wr = 1'b0;
    check("R10 masked irq", irq, 1);
    clear_all();
    check("R10 irq drops with event", irq, 0);
  endtask

  initial begin
    rst_n = 0; rx_line = 1; bit_tick = 0; char_valid = 0; char_data = 0; char_stop = 1;
    err_parity = 0; err_framing = 0; err_overrun = 0; err_cd_lost = 0;
    buf_close = 0; buf_avail = 1; evt_clr = 0; mask_wr = 0; mask_wdata = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_idle();
    t_break();
    t_busy();
    t_rxbuf();
    t_w1c();
    t_irq();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule